// File: doc/BRIEF.md
# Receive Idle Gap Time-out Detector

This block sits beside a serial receiver and detects a quiet line after the last character. The driver can then treat that gap as the end of a frame whose length it did not know in advance. The receiver supplies two pulses. The first is a one-cycle tick for each bit period. The second is a one-cycle pulse for each character it completes. A 16-bit time-out value sets how many bit periods of silence are allowed. Each character restarts the countdown from that value. When the countdown runs out, a sticky status flag is raised, and an interrupt line follows it when the enable is high.

The driver has two command strobes. The arm command clears the flag and parks the countdown until the next character arrives, so the idle line between frames cannot cause a second time-out. The retrigger command clears the flag and starts a fresh countdown at once, without waiting for a character. A time-out value of zero turns detection off.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the flag and the interrupt are 0 and the countdown is parked, so bit ticks alone never raise the flag.
- R2: While the time-out value is 0, the flag is 0 from the next cycle on and no time-out is detected, whatever ticks, characters or commands arrive.
- R3: With a value N ≥ 1, a character loads the countdown with N. The flag becomes 1 in the cycle after the N-th bit tick that follows the character, and not earlier.
- R4: The countdown moves only on bit-tick cycles. Clock cycles without a tick leave it unchanged, however many there are.
- R5: A character that arrives during a countdown reloads it, so N further ticks are needed after that character.
- R6: Once set, the flag stays 1 until an arm or retrigger command clears it or the value becomes 0. After it expires, the countdown stays parked until reloaded.
- R7: An arm command clears the flag in the next cycle and parks the countdown. Ticks that follow it raise nothing until a character arrives.
- R8: A retrigger command clears the flag and loads the countdown with the current value. The flag rises again after N more ticks with no character needed.
- R9: A change of the time-out value does not alter a countdown in progress. The new value is used at the next reload.
- R10: If a character and the final tick fall in the same cycle, the reload wins and the flag is not set.
- R11: The interrupt output is 1 exactly when the flag is 1 and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| to_value | input | 16 | Idle time-out length in bit periods, 0 disables |
| cmd_arm | input | 1 | Clear flag and park countdown until next character |
| cmd_retrig | input | 1 | Clear flag and restart countdown immediately |
| irq_en | input | 1 | Interrupt enable |
| timeout_flag | output | 1 | Sticky idle time-out status |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps small time-out values against several tick spacings, so an off-by-one countdown raises the flag one tick early or late, and a design that counts clocks instead of ticks fires during the idle gaps. Reloads in mid-count and a value change in mid-count are aimed at designs that ignore a character or apply the new value too soon. The bench pairs a character with the final tick to catch a design that lets the expiry win. It also runs long tick streams after reset, after an arm command and with a value of zero, which exposes a countdown that is not parked or a disable that does not hold.

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         char_rx,
  input  logic [W-1:0] to_value,
  input  logic         cmd_arm,
  input  logic         cmd_retrig,
  input  logic         irq_en,
  output logic         timeout_flag,
  output logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;
  logic         running;
  logic         disabled;
  logic         reload;
  logic         last_tick;

  assign disabled  = (to_value == '0);
  assign reload    = char_rx || cmd_retrig;
  assign last_tick = running && bit_tick && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (disabled) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (reload) begin
      cnt     <= to_value;
      running <= 1'b1;
    end else if (cmd_arm) begin
      running <= 1'b0;
    end else if (running && bit_tick) begin
      cnt     <= cnt - ONE;
      running <= (cnt != ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      timeout_flag <= 1'b0;
    else if (disabled || cmd_arm || cmd_retrig)
      timeout_flag <= 1'b0;
    else if (last_tick && !char_rx)
      timeout_flag <= 1'b1;
  end

  assign irq = timeout_flag && irq_en;

  // R2
  zero_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_value == '0) |=> !timeout_flag);

  // R4
  no_tick_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !timeout_flag) |=> !timeout_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !cmd_arm && !cmd_retrig && to_value != '0) |=> timeout_flag);

  // R7
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_arm |=> !timeout_flag);

  // R7
  parked_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reload) |=> !$rose(timeout_flag));

  // R8
  retrig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_retrig |=> !timeout_flag);

  // R10
  char_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_rx && !timeout_flag) |=> !timeout_flag);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0, char_rx = 1'b0, cmd_arm = 1'b0, cmd_retrig = 1'b0, irq_en = 1'b0;
  logic [15:0] to_value = 16'd0;
  logic        timeout_flag, irq;
  int          n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  rx_idle_timeout #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rx(char_rx),
    .to_value(to_value), .cmd_arm(cmd_arm), .cmd_retrig(cmd_retrig),
    .irq_en(irq_en), .timeout_flag(timeout_flag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic c, input logic a, input logic r);
    bit_tick = t; char_rx = c; cmd_arm = a; cmd_retrig = r;
    @(negedge clk);
    bit_tick = 0; char_rx = 0; cmd_arm = 0; cmd_retrig = 0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) step(1, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 flag at reset", timeout_flag, 0);
    chk("R1 irq at reset", irq, 0);
    rst_n = 1; to_value = 16'd3; irq_en = 1;
    @(negedge clk);
    ticks(20);
    chk("R1 parked after reset", timeout_flag, 0);

    // R3 R4: sweep of value and tick spacing
    for (int n = 1; n <= 8; n++) begin
      for (int gap = 0; gap <= 2; gap++) begin
        to_value = 16'(n);
        step(0, 0, 1, 0);
        step(0, 1, 0, 0);
        for (int k = 1; k <= n; k++) begin
          for (int g = 0; g < gap; g++) step(0, 0, 0, 0);
          chk("R4 no rise between ticks", timeout_flag, 0);
          step(1, 0, 0, 0);
          chk("R3 rise after N-th tick", timeout_flag, (k == n) ? 1 : 0);
        end
        ticks(3);
        chk("R6 sticky after expiry", timeout_flag, 1);
      end
    end

    // R11
    irq_en = 0; @(negedge clk);
    chk("R11 irq gated off", irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R11 irq follows flag", irq, 1);

    // R7
    step(0, 0, 1, 0);
    chk("R7 arm clears flag", timeout_flag, 0);
    chk("R11 irq low with flag low", irq, 0);
    ticks(30);
    chk("R7 parked until char", timeout_flag, 0);

    // R8
    to_value = 16'd4;
    step(0, 0, 0, 1);
    ticks(3);
    chk("R8 retrig not yet", timeout_flag, 0);
    ticks(1);
    chk("R8 retrig expiry", timeout_flag, 1);
    step(0, 0, 0, 1);
    chk("R8 retrig clears flag", timeout_flag, 0);
    ticks(4);
    chk("R8 second expiry", timeout_flag, 1);

    // R5
    step(0, 0, 1, 0);
    to_value = 16'd5;
    step(0, 1, 0, 0);
    ticks(4);
    step(0, 1, 0, 0);
    ticks(4);
    chk("R5 reload extends", timeout_flag, 0);
    ticks(1);
    chk("R5 expiry after reload", timeout_flag, 1);

    // R9
    step(0, 0, 1, 0);
    to_value = 16'd5;
    step(0, 1, 0, 0);
    ticks(1);
    to_value = 16'd2;
    ticks(3);
    chk("R9 old value still counting", timeout_flag, 0);
    ticks(1);
    chk("R9 old value expiry", timeout_flag, 1);
    step(0, 0, 1, 0);
    step(0, 1, 0, 0);
    ticks(2);
    chk("R9 new value at reload", timeout_flag, 1);

    // R10
    step(0, 0, 1, 0);
    to_value = 16'd3;
    step(0, 1, 0, 0);
    ticks(2);
    step(1, 1, 0, 0);
    chk("R10 char beats final tick", timeout_flag, 0);
    ticks(2);
    chk("R10 reloaded count", timeout_flag, 0);
    ticks(1);
    chk("R10 expiry after reload", timeout_flag, 1);

    // R2
    to_value = 16'd0;
    @(negedge clk);
    chk("R2 zero clears flag", timeout_flag, 0);
    step(0, 1, 0, 0);
    ticks(40);
    step(0, 0, 0, 1);
    ticks(40);
    chk("R2 disabled stays low", timeout_flag, 0);
    chk("R2 irq stays low", irq, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule